// File: doc/BRIEF.md
# UART FIFO Trigger-Level Interrupt Generator

This block holds the transmit and receive byte queues of one UART channel and derives that channel's two interrupt levels from queue occupancy. The host pushes bytes for transmission and pops received bytes. On the far side, a serializer takes transmit bytes and delivers received ones. A control byte sets the queue mode. Its bit 0 switches between deep queues of `DEPTH` bytes and a single holding byte per direction. Its bit 3 selects block transfer mode, which does not change the interrupt levels.

When queues are off, each direction holds one byte. The transmit level is high when the holding byte is empty. The receive level is high when a byte is waiting. When queues are on, each level compares occupancy against its own programmable trigger. Two status outputs report that the transmitter has room for another byte and that it is completely empty.

Top module: `fifo_trig_irq`

## Requirements
- R1: After reset both queues are empty: `txIrq`=1, `rxIrq`=0, `txSpace`=1, `txEmpty`=1.
- R2: With `ctlByte[0]`=0 the transmit side holds at most one byte. `txIrq` is 0 while that byte is held and 1 when it is empty. Further writes while it is held are dropped, and `txTrig` has no effect.
- R3: With `ctlByte[0]`=0 the receive side holds at most one byte. `rxIrq` is 1 while a byte is held and 0 otherwise. Further pushes are dropped, and `rxTrig` has no effect.
- R4: With `ctlByte[0]`=1, `txIrq` is 1 when transmit occupancy is less than or equal to `txTrig` (this includes empty) and 0 when it is greater.
- R5: With `ctlByte[0]`=1, `rxIrq` is 1 when receive occupancy is greater than or equal to `rxTrig` and 0 when it is less.
- R6: `ctlByte[3]` (block mode) has no effect on `txIrq` or `rxIrq`.
- R7: `txSpace` is 1 when transmit occupancy is below the capacity (`DEPTH` when queues are on, 1 when off). `txEmpty` is 1 exactly when transmit occupancy is zero.
- R8: A write to a full transmit queue is dropped. Bytes already queued stay intact.
- R9: A read from an empty receive queue leaves `rxRdData` at its last value and does not change occupancy.
- R10: Any change of `ctlByte[0]` empties both queues on the next clock edge.
- R11: Each queue returns bytes in first-in first-out order. Read data appears on the clock edge that accepts the read.
- R12: Write, push, pop and read strobes that arrive in the same cycle as a change of `ctlByte[0]` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctlByte | input | 8 | Control byte: bit 0 queue enable, bit 3 block mode |
| txTrig | input | $clog2(DEPTH+1) | Transmit trigger level |
| rxTrig | input | $clog2(DEPTH+1) | Receive trigger level |
| txWrEn | input | 1 | Host write into the transmit queue |
| txWrData | input | W | Byte to transmit |
| txPopReq | input | 1 | Serializer takes a transmit byte |
| txPopData | output | W | Byte taken by the serializer |
| rxPushReq | input | 1 | Serializer delivers a received byte |
| rxPushData | input | W | Received byte |
| rxRdEn | input | 1 | Host read from the receive queue |
| rxRdData | output | W | Byte read by the host |
| txIrq | output | 1 | Transmit interrupt level |
| rxIrq | output | 1 | Receive interrupt level |
| txSpace | output | 1 | Transmitter can accept a byte |
| txEmpty | output | 1 | Transmitter completely empty |

## Verification
The hardest case to reach is a strobe that coincides with a change of the enable bit. The flush and the strobe compete in the same cycle, and the flush must win. The bench raises the enable bit in the same cycle as a transmit write and a receive push. It then shows at the ports that both queues stayed empty. The trigger comparisons are walked through a vector table. Each vector first toggles the enable bit to empty the queues, then fills them to a chosen depth, and includes occupancies exactly at the trigger level and at capacity.

// File: rtl/fifo_trig_pkg.sv
package fifo_trig_pkg;
  // Qualified strobes from control to datapath
  typedef struct packed {
    logic txPush;
    logic txPop;
    logic rxPush;
    logic rxPop;
    logic flush;
  } fifoStrb_t;
endpackage

// File: rtl/fifo_trig_buf.sv
module fifo_trig_buf #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          flush,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  wrData,
  output logic [W-1:0]  rdData,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wrPtr, rdPtr;

  function automatic logic [PW-1:0] nextPtr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      count  <= '0;
      rdData <= '0;
    end else if (flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= nextPtr(wrPtr);
      if (pop) begin
        rdPtr  <= nextPtr(rdPtr);
        rdData <= mem[rdPtr];
      end
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  p_count_bound_r8: assert property (@(posedge clk) disable iff (!rstN)
    count <= CW'(DEPTH));
  p_flush_empties_r10: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> count == '0);
  p_data_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !pop |=> $stable(rdData));
  p_push_step_r11: assert property (@(posedge clk) disable iff (!rstN)
    (push && !pop && !flush) |=> count == $past(count) + 1'b1);
endmodule

// File: rtl/fifo_trig_dp.sv
module fifo_trig_dp
  import fifo_trig_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  fifoStrb_t     strb,
  input  logic [W-1:0]  txWrData,
  input  logic [W-1:0]  rxPushData,
  output logic [W-1:0]  txPopData,
  output logic [W-1:0]  rxRdData,
  output logic [CW-1:0] txCount,
  output logic [CW-1:0] rxCount
);
  fifo_trig_buf #(.DEPTH(DEPTH), .W(W)) txBuf (
    .clk(clk), .rstN(rstN), .flush(strb.flush),
    .push(strb.txPush), .pop(strb.txPop),
    .wrData(txWrData), .rdData(txPopData), .count(txCount)
  );

  fifo_trig_buf #(.DEPTH(DEPTH), .W(W)) rxBuf (
    .clk(clk), .rstN(rstN), .flush(strb.flush),
    .push(strb.rxPush), .pop(strb.rxPop),
    .wrData(rxPushData), .rdData(rxRdData), .count(rxCount)
  );
endmodule

// File: rtl/fifo_trig_ctrl.sv
module fifo_trig_ctrl
  import fifo_trig_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [7:0]    ctlByte,
  input  logic [CW-1:0] txTrig,
  input  logic [CW-1:0] rxTrig,
  input  logic          txWrEn,
  input  logic          txPopReq,
  input  logic          rxPushReq,
  input  logic          rxRdEn,
  input  logic [CW-1:0] txCount,
  input  logic [CW-1:0] rxCount,
  output fifoStrb_t     strb,
  output logic          txIrq,
  output logic          rxIrq,
  output logic          txSpace,
  output logic          txEmpty
);
  localparam int EN_BIT = 0;

  logic          fifoEn, prevEn;
  logic [CW-1:0] cap;
  logic          unusedCtl;

  // Block mode (bit 3) and the spare bits only steer ready signalling elsewhere
  assign unusedCtl = ^{ctlByte[7:1]};
  assign fifoEn    = ctlByte[EN_BIT];
  assign cap       = fifoEn ? CW'(DEPTH) : CW'(1);

  always_ff @(posedge clk) begin
    if (!rstN) prevEn <= 1'b0;
    else       prevEn <= fifoEn;
  end

  always_comb begin
    strb.flush  = fifoEn != prevEn;
    strb.txPush = txWrEn    && (txCount < cap) && !strb.flush;
    strb.txPop  = txPopReq  && (txCount != '0) && !strb.flush;
    strb.rxPush = rxPushReq && (rxCount < cap) && !strb.flush;
    strb.rxPop  = rxRdEn    && (rxCount != '0) && !strb.flush;
  end

  always_comb begin
    txIrq   = fifoEn ? (txCount <= txTrig) : (txCount == '0);
    rxIrq   = fifoEn ? (rxCount >= rxTrig) : (rxCount != '0);
    txSpace = txCount < cap;
    txEmpty = txCount == '0;
  end

  p_single_entry_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!fifoEn && !strb.flush) |-> (txCount <= CW'(1) && rxCount <= CW'(1)));
  p_full_drop_r8: assert property (@(posedge clk) disable iff (!rstN)
    (txWrEn && !txPopReq && !strb.flush && txCount == CW'(DEPTH)) |=> txCount == CW'(DEPTH));
  p_empty_read_r9: assert property (@(posedge clk) disable iff (!rstN)
    (rxRdEn && !rxPushReq && !strb.flush && rxCount == '0) |=> rxCount == '0);
  p_empty_has_room_r7: assert property (@(posedge clk) disable iff (!rstN)
    txEmpty |-> txSpace);
endmodule

// File: rtl/fifo_trig_irq.sv
module fifo_trig_irq
  import fifo_trig_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [7:0]    ctlByte,
  input  logic [CW-1:0] txTrig,
  input  logic [CW-1:0] rxTrig,
  input  logic          txWrEn,
  input  logic [W-1:0]  txWrData,
  input  logic          txPopReq,
  output logic [W-1:0]  txPopData,
  input  logic          rxPushReq,
  input  logic [W-1:0]  rxPushData,
  input  logic          rxRdEn,
  output logic [W-1:0]  rxRdData,
  output logic          txIrq,
  output logic          rxIrq,
  output logic          txSpace,
  output logic          txEmpty
);
  fifoStrb_t     strb;
  logic [CW-1:0] txCount, rxCount;

  fifo_trig_ctrl #(.DEPTH(DEPTH)) ctrl (
    .clk(clk), .rstN(rstN), .ctlByte(ctlByte),
    .txTrig(txTrig), .rxTrig(rxTrig),
    .txWrEn(txWrEn), .txPopReq(txPopReq),
    .rxPushReq(rxPushReq), .rxRdEn(rxRdEn),
    .txCount(txCount), .rxCount(rxCount), .strb(strb),
    .txIrq(txIrq), .rxIrq(rxIrq), .txSpace(txSpace), .txEmpty(txEmpty)
  );

  fifo_trig_dp #(.DEPTH(DEPTH), .W(W)) dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .txWrData(txWrData), .rxPushData(rxPushData),
    .txPopData(txPopData), .rxRdData(rxRdData),
    .txCount(txCount), .rxCount(rxCount)
  );
endmodule

// File: tb/fifo_trig_irq_test.sv
module fifo_trig_irq_test;
  localparam int DEPTH = 16;
  localparam int W     = 8;
  localparam int CW    = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] ctlByte = '0;
  logic [CW-1:0] txTrig = '0, rxTrig = '0;
  logic txWrEn = 0, txPopReq = 0, rxPushReq = 0, rxRdEn = 0;
  logic [W-1:0] txWrData = '0, rxPushData = '0;
  logic [W-1:0] txPopData, rxRdData;
  logic txIrq, rxIrq, txSpace, txEmpty;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  fifo_trig_irq #(.DEPTH(DEPTH), .W(W)) uut (
    .clk(clk), .rstN(rstN), .ctlByte(ctlByte), .txTrig(txTrig), .rxTrig(rxTrig),
    .txWrEn(txWrEn), .txWrData(txWrData), .txPopReq(txPopReq), .txPopData(txPopData),
    .rxPushReq(rxPushReq), .rxPushData(rxPushData), .rxRdEn(rxRdEn), .rxRdData(rxRdData),
    .txIrq(txIrq), .rxIrq(rxIrq), .txSpace(txSpace), .txEmpty(txEmpty)
  );

  // {en, blk, trig[4:0], fill[4:0], expTx, expRx}
  localparam int NV = 11;
  localparam logic [13:0] VEC [NV] = '{
    {1'b1, 1'b0, 5'd4,  5'd3,  1'b1, 1'b0},  // R4 R5 below trigger
    {1'b1, 1'b0, 5'd4,  5'd4,  1'b1, 1'b1},  // R4 R5 equal to trigger
    {1'b1, 1'b0, 5'd4,  5'd5,  1'b0, 1'b1},  // R4 R5 above trigger
    {1'b1, 1'b1, 5'd4,  5'd5,  1'b0, 1'b1},  // R6 block mode above
    {1'b1, 1'b1, 5'd4,  5'd3,  1'b1, 1'b0},  // R6 block mode below
    {1'b1, 1'b0, 5'd16, 5'd16, 1'b1, 1'b1},  // R4 R5 full at top trigger
    {1'b1, 1'b0, 5'd1,  5'd0,  1'b1, 1'b0},  // R4 R5 empty
    {1'b1, 1'b0, 5'd8,  5'd16, 1'b0, 1'b1},  // R4 R5 full
    {1'b0, 1'b0, 5'd4,  5'd1,  1'b0, 1'b1},  // R2 R3 trigger ignored
    {1'b0, 1'b1, 5'd0,  5'd0,  1'b1, 1'b0},  // R2 R3 empty single mode
    {1'b0, 1'b0, 5'd16, 5'd3,  1'b0, 1'b1}   // R2 R3 extra bytes dropped
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // Toggle enable off then to the target so both queues start empty
  task automatic setMode(input logic en, input logic blk);
    ctlByte = {7'b0, ~en};
    tick(); tick();
    ctlByte = {4'b0, blk, 2'b0, en};
    tick(); tick();
  endtask

  task automatic pushTx(input logic [W-1:0] d);
    txWrEn = 1; txWrData = d; tick(); txWrEn = 0;
  endtask

  task automatic popTx();
    txPopReq = 1; tick(); txPopReq = 0;
  endtask

  task automatic pushRx(input logic [W-1:0] d);
    rxPushReq = 1; rxPushData = d; tick(); rxPushReq = 0;
  endtask

  task automatic readRx();
    rxRdEn = 1; tick(); rxRdEn = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual running expected done");
    summary();
  end

  initial begin
    tick(); tick();
    rstN = 1;
    tick();
    // R1 reset state
    check("R1 txIrq", txIrq, 1);
    check("R1 rxIrq", rxIrq, 0);
    check("R1 txSpace", txSpace, 1);
    check("R1 txEmpty", txEmpty, 1);

    // Trigger comparison table
    for (int i = 0; i < NV; i++) begin
      setMode(VEC[i][13], VEC[i][12]);
      txTrig = VEC[i][11:7];
      rxTrig = VEC[i][11:7];
      for (int k = 0; k < int'(VEC[i][6:2]); k++) begin
        txWrEn = 1; txWrData = W'(k); rxPushReq = 1; rxPushData = W'(k);
        tick();
        txWrEn = 0; rxPushReq = 0;
      end
      check($sformatf("R4 R2 vec%0d txIrq", i), txIrq, VEC[i][1]);
      check($sformatf("R5 R3 vec%0d rxIrq", i), rxIrq, VEC[i][0]);
    end

    // R8 R11 R7: fill transmit queue past capacity, drain in order
    setMode(1, 0);
    txTrig = 5'd15;
    for (int k = 0; k < DEPTH + 1; k++) pushTx(W'(8'h10 + k));
    check("R7 txSpace full", txSpace, 0);
    check("R7 txEmpty full", txEmpty, 0);
    check("R4 txIrq above", txIrq, 0);
    for (int k = 0; k < DEPTH; k++) begin
      popTx();
      check("R11 R8 order", txPopData, W'(8'h10 + k));
    end
    check("R7 txEmpty drained", txEmpty, 1);
    popTx();
    check("R8 no dropped byte stored", txPopData, W'(8'h1F));

    // R2: single holding byte on transmit side
    setMode(0, 0);
    txTrig = 5'd16;
    pushTx(8'hA5);
    check("R2 txIrq held", txIrq, 0);
    check("R7 txSpace single", txSpace, 0);
    pushTx(8'h5A);
    popTx();
    check("R2 held byte", txPopData, 8'hA5);
    check("R2 txIrq empty", txIrq, 1);
    popTx();
    check("R2 second write dropped", txPopData, 8'hA5);

    // R9: read from empty receive queue
    setMode(1, 0);
    rxTrig = 5'd1;
    pushRx(8'h31); pushRx(8'h32);
    readRx(); check("R11 rx first", rxRdData, 8'h31);
    readRx(); check("R11 rx second", rxRdData, 8'h32);
    readRx(); check("R9 empty read holds", rxRdData, 8'h32);
    check("R9 rxIrq empty", rxIrq, 0);
    pushRx(8'h33);
    check("R9 count one", rxIrq, 1);
    readRx(); check("R9 pointer intact", rxRdData, 8'h33);

    // R10: enable change empties both queues
    pushTx(8'h01); pushRx(8'h02); pushRx(8'h03);
    ctlByte = 8'h00; tick();
    check("R10 tx cleared", txEmpty, 1);
    check("R10 rx cleared", rxIrq, 0);

    // R12: strobes in the cycle of an enable change are ignored
    ctlByte = 8'h01;
    txWrEn = 1; txWrData = 8'h77; rxPushReq = 1; rxPushData = 8'h66;
    tick();
    txWrEn = 0; rxPushReq = 0;
    tick();
    check("R12 tx write ignored", txEmpty, 1);
    rxTrig = 5'd1;
    check("R12 rx push ignored", rxIrq, 0);

    summary();
  end
endmodule